// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-side controller of a byte-wide nonvolatile memory that a host reaches over a two-wire serial bus (a clock line and an open-drain data line). It follows both lines with its own system clock, recognises START and STOP conditions, and answers a device-select byte whose hardware-address bits match two strap inputs. Up to four devices can therefore share one bus. A write transaction loads a 13-bit word address and then up to a page of 32 data bytes into a page buffer. Sequential reads return bytes MSB first for as long as the host acknowledges.

The buffered page is written to the storage array only when a STOP ends the write. A self-timed busy interval then starts, with its length set by a parameter in system clocks. While it runs, the controller releases the bus completely, so the host can poll with device-select bytes until one is acknowledged. The data line output is an active-high "pull low" request for an open-drain pad. The storage array holds 2^STORE_AW bytes and is indexed by the low bits of the 13-bit word address.

Top module: `e2_serial_eeprom`

## Requirements
- R1: After reset the controller does not pull the data line and acknowledges a matching device-select byte at once.
- R2: A device-select byte is acknowledged only when bits 7..4 are 1010, bit 3 equals strap_s2 and bit 2 equals strap_s1. Bit 1 is ignored and bit 0 is read (1) or write (0). On a mismatch there is no acknowledge, and later bytes are ignored until the next START.
- R3: A write transaction takes the address high byte (bits 4..0 become address bits 12..8, bits 7..5 are ignored) and then the low byte. A single data byte written after them is stored at that address.
- R4: In a page write, each data byte goes to the current address. The low 5 address bits then step and wrap within the 32-byte page while bits 12..5 stay fixed, so more than 32 bytes overwrite earlier ones.
- R5: Write data reaches the array only when a STOP ends the transaction. A START before that STOP discards the buffered bytes and starts no busy interval.
- R6: A STOP that ends a transaction carrying write data starts a busy interval of WR_CYCLES clocks. During it no byte is acknowledged and the data line is never pulled. Afterwards the device acknowledges again.
- R7: A read transaction drives each byte MSB first. After each byte the 13-bit address counter increments, rolling over from 1FFFh to 0000h. A host ACK (data line low) requests the next byte and a NACK ends the read.
- R8: A read device-select without a preceding address starts at the address after the last byte accessed.
- R9: Word addresses that differ only above bit STORE_AW-1 select the same storage byte.
- R10: A STOP in the middle of a data byte drops that partial byte. Any complete bytes buffered before it are still written, followed by the busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_s1 | input | 1 | Hardware address strap compared with select bit 2 |
| strap_s2 | input | 1 | Hardware address strap compared with select bit 3 |
| sda_pull_o | output | 1 | High requests the open-drain pad to pull the data line low |

## Verification
A bus STOP can land in the same system cycle as a pending page of write data and an unfinished data byte. The controller must then start the busy interval and commit the complete bytes in that cycle, while dropping the partial byte. The bench provokes this by sending one full data byte and then four bits of another before issuing STOP. It judges the outcome at the ports: the first poll must get no acknowledge, and reading back must show the full byte written and the following address unchanged. Random byte writes and reads are checked against a bench model of the array, and directed cases cover page wrap, rollover at 1FFFh and aliasing.

// File: rtl/e2_pkg.sv
package e2_pkg;
  localparam int ADDR_W = 13;
  localparam int PAGE_W = 5;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef logic [ADDR_W-1:0] waddr_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK, ST_RNXT
  } e2_state_t;

  // next write address: low page bits wrap, page number held
  function automatic waddr_t page_step(waddr_t a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  // next read address: whole counter, natural rollover
  function automatic waddr_t seq_step(waddr_t a);
    return a + ADDR_W'(1);
  endfunction

  // bit 1 is masked out, bit 0 is direction
  function automatic logic dev_match(logic [7:0] b, logic s1, logic s2);
    return (b & 8'hFC) == {DEV_TYPE, s2, s1, 2'b00};
  endfunction
endpackage

// File: rtl/e2_line_events.sv
module e2_line_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int TOP = SYNC_STAGES;

  logic [TOP:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[TOP-1:0], scl_i};
      sda_q <= {sda_q[TOP-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now  = scl_q[TOP-1];
  assign scl_old  = scl_q[TOP];
  assign sda_lvl  = sda_q[TOP-1];
  assign sda_old  = sda_q[TOP];
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_ev = scl_now & scl_old & sda_old & ~sda_lvl;
  assign stop_ev  = scl_now & scl_old & ~sda_old & sda_lvl;
endmodule

// File: rtl/e2_wtimer.sv
module e2_wtimer #(
  parameter int WR_CYCLES  = 500000,
  parameter int PAGE_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          kick,
  output logic                          busy,
  output logic                          cmt_en,
  output logic [$clog2(PAGE_BYTES)-1:0] cmt_idx
);
  // the interval must at least cover one commit slot per page byte
  localparam int SPAN = (WR_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WR_CYCLES;
  localparam int CW   = $clog2(SPAN + 1);
  localparam int IW   = $clog2(PAGE_BYTES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (kick && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CW'(SPAN - 1)) busy <= 1'b0;
      else cnt <= cnt + CW'(1);
    end
  end

  assign cmt_en  = busy && (cnt < CW'(PAGE_BYTES));
  assign cmt_idx = cnt[IW-1:0];

  // R6
  kick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !busy) |=> busy);
endmodule

// File: rtl/e2_store.sv
module e2_store
  import e2_pkg::*;
#(
  parameter int STORE_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  waddr_t            wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cmt_en,
  input  logic [PAGE_W-1:0] cmt_idx,
  input  logic [STORE_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int DEPTH      = 1 << STORE_AW;

  logic [7:0]              mem  [DEPTH];
  logic [7:0]              pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]   vld;
  logic [ADDR_W-PAGE_W-1:0] base;
  waddr_t                  cmt_addr;

  assign cmt_addr = {base, cmt_idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      base <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_addr[PAGE_W-1:0]] <= 1'b1;
      base <= wr_addr[ADDR_W-1:PAGE_W];
    end else if (cmt_en) begin
      vld[cmt_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) pbuf[wr_addr[PAGE_W-1:0]] <= wr_data;
    if (cmt_en && vld[cmt_idx]) mem[cmt_addr[STORE_AW-1:0]] <= pbuf[cmt_idx];
  end

  assign rd_data = mem[rd_addr];

  // R5
  cmt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cmt_en);
endmodule

// File: rtl/e2_serial_eeprom.sv
module e2_serial_eeprom
  import e2_pkg::*;
#(
  parameter int STORE_AW    = 10,
  parameter int WR_CYCLES   = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_s1,
  input  logic strap_s2,
  output logic sda_pull_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, cmt_en;
  logic [PAGE_W-1:0] cmt_idx;
  logic [7:0] rd_data;

  e2_state_t st, nxt;
  logic [2:0] bcnt;
  logic [6:0] sh;
  logic [7:0] rsh;
  logic       ack_ph, wr_pend;
  waddr_t     addr;

  // named internal events
  logic [7:0] inb;
  logic live, byte_done, dev_hit, wr_byte_ev, rd_adv_ev, kick, discard;
  assign inb        = {sh, sda_lvl};
  assign live       = !busy && !start_ev && !stop_ev;
  assign byte_done  = live && scl_rise && (bcnt == 3'd7);
  assign dev_hit    = dev_match(inb, strap_s1, strap_s2);
  assign wr_byte_ev = byte_done && (st == ST_WDAT);
  assign rd_adv_ev  = byte_done && (st == ST_RDAT);
  assign kick       = stop_ev && wr_pend && !busy;
  assign discard    = start_ev && !busy;

  e2_line_events #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  e2_wtimer #(.WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy),
    .cmt_en(cmt_en), .cmt_idx(cmt_idx)
  );

  e2_store #(.STORE_AW(STORE_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(discard), .wr_en(wr_byte_ev),
    .wr_addr(addr), .wr_data(inb), .cmt_en(cmt_en), .cmt_idx(cmt_idx),
    .rd_addr(addr[STORE_AW-1:0]), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt <= ST_IDLE; bcnt <= '0; sh <= '0; rsh <= '0;
      ack_ph <= 1'b0; wr_pend <= 1'b0; addr <= '0; sda_pull_o <= 1'b0;
    end else if (busy) begin
      st <= ST_IDLE; sda_pull_o <= 1'b0; wr_pend <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; sda_pull_o <= 1'b0; wr_pend <= 1'b0;
    end else if (start_ev) begin
      st <= ST_DEV; bcnt <= '0; sda_pull_o <= 1'b0; wr_pend <= 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise) begin
            sh   <= inb[6:0];
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              st     <= ST_ACK;
              ack_ph <= 1'b0;
              case (st)
                ST_DEV: begin
                  if (!dev_hit) st <= ST_IDLE;
                  nxt <= inb[0] ? ST_RDAT : ST_AHI;
                end
                ST_AHI: begin
                  addr[ADDR_W-1:8] <= inb[ADDR_W-9:0];
                  nxt <= ST_ALO;
                end
                ST_ALO: begin
                  addr[7:0] <= inb;
                  nxt <= ST_WDAT;
                end
                default: begin
                  addr    <= page_step(addr);
                  wr_pend <= 1'b1;
                  nxt     <= ST_WDAT;
                end
              endcase
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_ph) begin
              sda_pull_o <= 1'b1;
              ack_ph     <= 1'b1;
            end else begin
              ack_ph <= 1'b0;
              bcnt   <= '0;
              st     <= nxt;
              if (nxt == ST_RDAT) begin
                sda_pull_o <= ~rd_data[7];
                rsh        <= {rd_data[6:0], 1'b0};
              end else begin
                sda_pull_o <= 1'b0;
              end
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            sda_pull_o <= ~rsh[7];
            rsh        <= {rsh[6:0], 1'b0};
          end else if (scl_rise) begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              st   <= ST_RACK;
              addr <= seq_step(addr);
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) sda_pull_o <= 1'b0;
          else if (scl_rise) st <= sda_lvl ? ST_IDLE : ST_RNXT;
        end
        ST_RNXT: begin
          if (scl_fall) begin
            sda_pull_o <= ~rd_data[7];
            rsh        <= {rd_data[6:0], 1'b0};
            bcnt       <= '0;
            st         <= ST_RDAT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);

  // R2
  dev_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV) |-> !sda_pull_o);

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_ev |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  // R7
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv_ev |=> addr == seq_step($past(addr)));

  // R7
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> $past(scl_fall || start_ev || stop_ev));
endmodule

// File: tb/sim_e2_serial_eeprom.sv
module sim_e2_serial_eeprom;
  localparam int SAW  = 10;
  localparam int WRC  = 400;
  localparam logic [7:0] SELW = 8'hA4;  // 1010, s2=0, s1=1, w
  localparam logic [7:0] SELR = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_h = 1'b1;
  logic sda_pull;
  wire  sda = sda_h & ~sda_pull;
  int   nchk = 0, nerr = 0;
  bit   done = 1'b0;
  logic [7:0] ref_mem [1 << SAW];

  always #5 clk = ~clk;

  e2_serial_eeprom #(.STORE_AW(SAW), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .strap_s1(1'b1), .strap_s2(1'b0), .sda_pull_o(sda_pull)
  );

  function automatic logic [12:0] nxt_page(logic [12:0] a);
    return (a & 13'h1FE0) | ((a + 13'd1) & 13'h001F);
  endfunction
  function automatic logic [12:0] nxt_seq(logic [12:0] a);
    return 13'((a + 13'd1) % 8192);
  endfunction
  function automatic int ridx(logic [12:0] a);
    return int'(a) % (1 << SAW);
  endfunction

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic tx_start();
    sda_h = 1'b1; quarter(); scl = 1'b1; quarter();
    sda_h = 1'b0; quarter(); scl = 1'b0;
  endtask

  task automatic tx_stop();
    quarter(); sda_h = 1'b0; quarter(); scl = 1'b1; quarter();
    sda_h = 1'b1; quarter();
  endtask

  task automatic put_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      quarter(); sda_h = b[i]; quarter(); scl = 1'b1;
      quarter(); quarter(); scl = 1'b0;
    end
  endtask

  task automatic put_byte(logic [7:0] b, output bit acked);
    put_bits(b, 8);
    quarter(); sda_h = 1'b1; quarter(); scl = 1'b1;
    quarter(); acked = ~sda; quarter(); scl = 1'b0;
  endtask

  task automatic get_byte(bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      quarter(); sda_h = 1'b1; quarter(); scl = 1'b1;
      quarter(); b[i] = sda; quarter(); scl = 1'b0;
    end
    quarter(); sda_h = nack; quarter(); scl = 1'b1;
    quarter(); quarter(); scl = 1'b0;
  endtask

  task automatic poll_ready(output int tries);
    bit a;
    tries = 0;
    for (int k = 0; k < 40; k++) begin
      tries++;
      tx_start(); put_byte(SELW, a); tx_stop();
      if (a) break;
    end
  endtask

  task automatic send_addr(logic [12:0] a, logic [2:0] junk);
    bit ak;
    tx_start();
    put_byte(SELW, ak); check("R2 select ack", int'(ak), 1);
    put_byte({junk, a[12:8]}, ak); check("R3 addr hi ack", int'(ak), 1);
    put_byte(a[7:0], ak); check("R3 addr lo ack", int'(ak), 1);
  endtask

  task automatic write_run(logic [12:0] a, int n, logic [7:0] first);
    bit ak;
    int tries;
    logic [12:0] p = a;
    logic [7:0] d;
    send_addr(a, 3'b000);
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? first : 8'($urandom);
      put_byte(d, ak);
      check("R4 data ack", int'(ak), 1);
      ref_mem[ridx(p)] = d;
      p = nxt_page(p);
    end
    tx_stop();
    poll_ready(tries);
    check("R6 busy after write", int'(tries > 1), 1);
  endtask

  task automatic read_run(logic [12:0] a, int n, string req);
    bit ak;
    logic [7:0] b;
    logic [12:0] p = a;
    send_addr(a, 3'b000);
    tx_start();
    put_byte(SELR, ak); check("R7 read select ack", int'(ak), 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i == n - 1, b);
      check(req, int'(b), int'(ref_mem[ridx(p)]));
      p = nxt_seq(p);
    end
    tx_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit ak;
    int tries;
    logic [7:0] b;
    logic [12:0] ra;
    logic [7:0] rd;
    void'($urandom(32'd1234));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: line released, immediate acknowledge
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      check("R1 sda released", int'(sda_pull), 0);
    end
    tx_start(); put_byte(SELW, ak); tx_stop();
    check("R1 ack after reset", int'(ak), 1);

    // R2: strap mismatch, then ignored byte; bit1 don't care
    tx_start(); put_byte(8'hA8, ak);
    check("R2 mismatch nack", int'(ak), 0);
    put_byte(8'hA4, ak);
    check("R2 ignored after mismatch", int'(ak), 0);
    tx_stop();
    tx_start(); put_byte(8'hA6, ak); tx_stop();
    check("R2 bit1 ignored", int'(ak), 1);
    tx_start(); put_byte(8'h24, ak); tx_stop();
    check("R2 wrong type nack", int'(ak), 0);

    // R3: byte write with junk upper address bits
    begin
      send_addr(13'h0123, 3'b111);
      put_byte(8'h9D, ak); check("R3 data ack", int'(ak), 1);
      tx_stop();
      ref_mem[ridx(13'h0123)] = 8'h9D;
      poll_ready(tries);
      check("R6 first poll nack", int'(tries > 1), 1);
      check("R6 ready again", int'(tries < 40), 1);
      read_run(13'h0123, 1, "R3 byte readback");
    end

    // R4: 35-byte page write wraps inside its page
    write_run(13'h0A3C, 35, 8'h11);
    read_run(13'h0A20, 32, "R4 page contents");

    // R7 rollover and R9 aliasing
    write_run(13'h1FFE, 2, 8'hE1);
    write_run(13'h0000, 1, 8'h0F);
    read_run(13'h1FFE, 3, "R7 rollover read");
    write_run(13'h0405, 1, 8'h6B);
    read_run(13'h0005, 1, "R9 alias read");
    check("R9 alias value", int'(ref_mem[ridx(13'h0005)]), 32'h6B);

    // R8: current address read continues after last byte (0x0005 -> 0x0006)
    write_run(13'h0006, 1, 8'hC4);
    read_run(13'h0005, 1, "R8 setup read");
    tx_start(); put_byte(SELR, ak);
    check("R8 select ack", int'(ak), 1);
    get_byte(1'b1, b); tx_stop();
    check("R8 current address", int'(b), 32'hC4);

    // R5: START before STOP discards buffered byte
    write_run(13'h0155, 1, 8'h3C);
    send_addr(13'h0155, 3'b000);
    put_byte(8'hC3, ak);
    tx_start(); put_byte(SELW, ak); tx_stop();
    check("R5 no busy after restart", int'(ak), 1);
    read_run(13'h0155, 1, "R5 discarded write");

    // R10: STOP inside a byte after one full byte
    write_run(13'h0778, 1, 8'h5A);
    send_addr(13'h0777, 3'b000);
    put_byte(8'h11, ak);
    put_bits(8'hFF, 4);
    tx_stop();
    ref_mem[ridx(13'h0777)] = 8'h11;
    poll_ready(tries);
    check("R10 busy after abort", int'(tries > 1), 1);
    read_run(13'h0777, 2, "R10 partial byte dropped");

    // random byte writes and reads
    for (int k = 0; k < 8; k++) begin
      ra = 13'($urandom);
      rd = 8'($urandom);
      write_run(ra, 1, rd);
      read_run(ra, 1, "R3 random readback");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule